// File: doc/BRIEF.md
# Bus Arbiter with Mixed Rotating and Fixed Priority

This block decides which of four bus masters owns a shared parallel bus. Three external masters and the host (CPU) master raise active-low requests; the arbiter answers with active-low grants, at most one low at a time. When nobody asks for the bus the grant rests on the host. A grant moving from one master to another always passes through one clock with every grant high, so two owners never overlap.

Priority comes from a three-node binary tree. One node chooses between masters 0 and 1, one between master 2 and the host, and the root chooses between the two pairs. Each node bit is taken from a rotating vector or from a programmed fixed vector, bit by bit under a keep mask. So the ordering can be fully rotating, fully fixed or a blend of the two. For each master, control bits enable preemption of its grant and enable masking of its request after one of its own cycles ends in a retry. A per-master timer flags an external master that holds the grant but never starts a cycle (frame input low). One write port and one read port hold the control fields and show the sticky status bits.

Top module: `pci_hybrid_arbiter`

## Requirements
- R1: After a synchronous reset, `gnt_n` is 4'b0111 (the grant rests on the host) and every bit of `rd_data` reads 0. With all control bits zero, every priority bit rotates, preemption is off and retry masking is off.
- R2: A new grant goes to the winner of the tree over the eligible requests (asserted and not masked). With effective bits e: e[0]=0 prefers master 0 over master 1, and e[0]=1 prefers master 1. e[1]=0 prefers master 2 over the host (index 3), and e[1]=1 prefers the host. e[2]=0 prefers the pair {0,1}, and e[2]=1 prefers the pair {2,host}. A node whose preferred side has no eligible request picks its other side.
- R3: Each grant given to a requesting master updates the rotating vector so that this master becomes least preferred. Master 0 sets bit0=1 and bit2=1. Master 1 sets bit0=0 and bit2=1. Master 2 sets bit1=1 and bit2=0. The host sets bit1=0 and bit2=0. Resting the grant on an idle host does not rotate.
- R4: Effective bit i is fixed-vector bit i (register bits [5:3]) when keep-mask bit i (register bits [2:0]) is 1, and rotating bit i otherwise. This covers mask 000 (all rotate), mask 111 (all fixed) and every mixed value.
- R5: At most one bit of `gnt_n` is low. Any change of owner passes through exactly one clock with `gnt_n` = 4'b1111.
- R6: An owner whose preemption bit is 0 keeps its grant for as long as its request stays eligible.
- R7: When the preemption bit of the owner is set (register bit 6+m, host m=3), the owner loses its grant if a master that is preferred over it has an eligible request. The owner also loses it when its own request goes away and another request is eligible, or, for an external owner, when no request is eligible at all.
- R8: When `retry` is high while master m owns the grant and its retry-mask bit is set (register bit 10+m), its request is masked from the next clock on.
- R9: A masked request is unmasked at the first clock edge at which a grant is given to a different master, or at which no other master has a raw request asserted.
- R10: If an external master m holds the grant for 16 clock edges after the edge that granted it, and `frame_n` is high at each of them, status bit 15+m is set and stays set.
- R11: Writing 1 to register bit 14 clears all status bits, and this clear wins over a detection at the same edge. Writes to bits [17:15] have no effect on them.
- R12: Bits [19:18] and bit 14 always read 0. Bits [13:0] read back the last value written.
- R13: With no request asserted, the grant comes to rest on the host (`gnt_n` = 4'b0111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 4 | Active-low requests: bits 0..2 external masters, bit 3 host |
| frame_n | input | 1 | Active-low cycle-start indication from the current owner |
| retry | input | 1 | High for one clock when the owner's cycle ends in a retry |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 20 | Write data: [2:0] keep mask, [5:3] fixed vector, [9:6] preemption enables, [13:10] retry-mask enables, [14] status clear |
| gnt_n | output | 4 | Active-low grants, same bit order as `req_n` |
| rd_data | output | 20 | Control fields in [13:0], status in [17:15], zeros elsewhere |

## Verification
Random request patterns that toggle slowly are applied under six control settings: all rotating, all fixed, a mixed keep mask, preemption on, retry masking on, and everything combined. Each setting separates a different part of the priority and ownership policy: tree order against rotation, correct bit selection by the keep mask, held grants against preempted ones, and correct masking and unmasking after retries. A timed single-master sequence checks the exact edge at which the broken-master flag sets (not 15 edges, but 16). Directed writes then show that the status bits ignore direct writes, clear on command, and that reserved positions stay zero.

// File: rtl/arb_pkg.sv
// Shared sizes and register field positions for the bus arbiter.
// Assumes four masters with a fixed binary tree of three priority nodes.
package arb_pkg;
    localparam int NM = 4;                     // masters, host last
    localparam int NE = NM - 1;                // external masters
    localparam int NV = 3;                     // tree node bits
    localparam logic [1:0] HOST_ID = 2'd3;

    localparam int KEEP_LSB = 0;
    localparam int FIX_LSB  = KEEP_LSB + NV;
    localparam int PRE_LSB  = FIX_LSB + NV;
    localparam int RTY_LSB  = PRE_LSB + NM;
    localparam int CLR_BIT  = RTY_LSB + NM;
    localparam int STAT_LSB = CLR_BIT + 1;
    localparam int RSV_LSB  = STAT_LSB + NE;
    localparam int CTRL_W   = RSV_LSB + 2;
endpackage

// File: rtl/arb_prio_tree.sv
// Picks one eligible master from a 3-node tree of preference bits.
// Assumes exactly four masters: pair A = {0,1}, pair B = {2,host}.
module arb_prio_tree
    import arb_pkg::*;
(
    input  logic [NM-1:0] elig,
    input  logic [NV-1:0] eff,
    output logic [1:0]    win_idx,
    output logic          win_v
);
    logic [1:0] pick_a, pick_b;
    logic       any_a, any_b;

    // Resolve each leaf node, then the root between the pairs.
    always_comb begin
        any_a  = elig[0] | elig[1];
        any_b  = elig[2] | elig[3];
        if (eff[0]) pick_a = elig[1] ? 2'd1 : 2'd0;
        else        pick_a = elig[0] ? 2'd0 : 2'd1;
        if (eff[1]) pick_b = elig[3] ? 2'd3 : 2'd2;
        else        pick_b = elig[2] ? 2'd2 : 2'd3;
        if (eff[2]) win_idx = any_b ? pick_b : pick_a;
        else        win_idx = any_a ? pick_a : pick_b;
        win_v = any_a | any_b;
    end
endmodule

// File: rtl/arb_stall_watch.sv
// Flags a master that holds the grant for TIMEOUT_CLKS edges without
// starting a cycle. Assumes 'start' pulses on the edge that grants it.
module arb_stall_watch #(
    parameter int TIMEOUT_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic held,
    input  logic start,
    input  logic frame_n,
    output logic hit
);
    localparam int CW = $clog2(TIMEOUT_CLKS + 1);
    logic [CW-1:0] cnt_q;
    logic          armed_q;

    assign hit = held && armed_q && frame_n && (cnt_q == CW'(TIMEOUT_CLKS - 1));

    // Count idle edges of a fresh grant until a cycle starts or time runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (held && armed_q) begin
            if (!frame_n || hit) armed_q <= 1'b0;
            else                 cnt_q   <= cnt_q + 1'b1;
        end else if (start) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/arb_cfg_regs.sv
// Control register and sticky broken-master status.
// Assumes a single-clock write strobe; reads are combinational.
module arb_cfg_regs
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [NE-1:0]     hit,
    output logic [NV-1:0]     keep,
    output logic [NV-1:0]     fixv,
    output logic [NM-1:0]     pre_en,
    output logic [NM-1:0]     rty_en,
    output logic [CTRL_W-1:0] rd_data
);
    logic [NE-1:0] stat_q;
    logic          unused_wr_bits;

    assign unused_wr_bits = ^wr_data[CTRL_W-1:STAT_LSB];

    // Hold control fields; writes replace all of them at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep   <= '0;
            fixv   <= '0;
            pre_en <= '0;
            rty_en <= '0;
        end else if (wr_en) begin
            keep   <= wr_data[KEEP_LSB +: NV];
            fixv   <= wr_data[FIX_LSB  +: NV];
            pre_en <= wr_data[PRE_LSB  +: NM];
            rty_en <= wr_data[RTY_LSB  +: NM];
        end
    end

    // Sticky status; a clear command overrides a same-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)                         stat_q <= '0;
        else if (wr_en && wr_data[CLR_BIT]) stat_q <= '0;
        else                                stat_q <= stat_q | hit;
    end

    // Assemble read data; reserved and clear positions stay zero.
    always_comb begin
        rd_data                     = '0;
        rd_data[KEEP_LSB +: NV]     = keep;
        rd_data[FIX_LSB  +: NV]     = fixv;
        rd_data[PRE_LSB  +: NM]     = pre_en;
        rd_data[RTY_LSB  +: NM]     = rty_en;
        rd_data[STAT_LSB +: NE]     = stat_q;
    end
endmodule

// File: rtl/pci_hybrid_arbiter.sv
// Four-master bus arbiter: tree priority mixing rotating and fixed bits,
// optional preemption, retry masking, broken-master detection.
// Assumes requests and frame are synchronous to clk; grant outputs are
// registered and a handover always inserts one idle clock.
module pci_hybrid_arbiter
    import arb_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NM-1:0]     req_n,
    input  logic              frame_n,
    input  logic              retry,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [NM-1:0]     gnt_n,
    output logic [CTRL_W-1:0] rd_data
);
    logic [NM-1:0] gnt_q, gnt_d, masked_q, masked_d, elig, req_v, other_req;
    logic [NV-1:0] rot_q, rot_d, eff, keep, fixv;
    logic [NM-1:0] pre_en, rty_en;
    logic [NE-1:0] hit;
    logic [1:0]    hold_idx, win_idx;
    logic          have, win_v, hreq, leave, issue;

    assign req_v = ~req_n;
    assign elig  = req_v & ~masked_q;
    assign eff   = (keep & fixv) | (~keep & rot_q);
    assign gnt_n = ~gnt_q;

    arb_prio_tree u_tree (
        .elig    (elig),
        .eff     (eff),
        .win_idx (win_idx),
        .win_v   (win_v)
    );

    // Encode the current owner.
    always_comb begin
        hold_idx = HOST_ID;
        for (int i = 0; i < NM; i++)
            if (gnt_q[i]) hold_idx = 2'(i);
        have = |gnt_q;
        hreq = elig[hold_idx];
    end

    // Decide whether the owner keeps, drops, or a new grant is issued.
    always_comb begin
        leave = have && (!hreq || pre_en[hold_idx])
                     && (win_v ? (win_idx != hold_idx) : (hold_idx != HOST_ID));
        issue = !have && win_v;
        gnt_d = gnt_q;
        if (!have)      gnt_d = win_v ? (NM'(1) << win_idx) : (NM'(1) << HOST_ID);
        else if (leave) gnt_d = '0;
    end

    // Move the served master to the least preferred rotating position.
    always_comb begin
        rot_d = rot_q;
        if (issue) begin
            if (!win_idx[1]) begin
                rot_d[0] = (win_idx == 2'd0);
                rot_d[2] = 1'b1;
            end else begin
                rot_d[1] = (win_idx == 2'd2);
                rot_d[2] = 1'b0;
            end
        end
    end

    // Set masks on a retry of the owner; release them so nobody starves.
    always_comb begin
        other_req = '0;
        for (int m = 0; m < NM; m++) begin
            other_req   = req_v & ~(NM'(1) << m);
            masked_d[m] = masked_q[m];
            if (masked_q[m] && ((issue && win_idx != 2'(m)) || other_req == '0))
                masked_d[m] = 1'b0;
            if (retry && have && hold_idx == 2'(m) && rty_en[m])
                masked_d[m] = 1'b1;
        end
    end

    // Register grant, rotation and mask state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q    <= NM'(1) << HOST_ID;
            rot_q    <= '0;
            masked_q <= '0;
        end else begin
            gnt_q    <= gnt_d;
            rot_q    <= rot_d;
            masked_q <= masked_d;
        end
    end

    for (genvar g = 0; g < NE; g++) begin : g_watch
        arb_stall_watch #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_watch (
            .clk     (clk),
            .rst_n   (rst_n),
            .held    (gnt_q[g]),
            .start   (gnt_d[g] & ~gnt_q[g]),
            .frame_n (frame_n),
            .hit     (hit[g])
        );
    end

    arb_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .hit     (hit),
        .keep    (keep),
        .fixv    (fixv),
        .pre_en  (pre_en),
        .rty_en  (rty_en),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/arb_checker.sv
// Protocol checks for the arbiter, bound to every instance of the top.
// Assumes the register layout described by the requirements.
module arb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  req_n,
    input logic        wr_en,
    input logic [19:0] wr_data,
    input logic [3:0]  gnt_n,
    input logic [19:0] rd_data,
    input logic [3:0]  masked
);
    // R1: reset parks the grant on the host and clears the register.
    a_r1_reset_park: assert property (@(posedge clk)
        !rst_n |=> (gnt_n == 4'b0111 && rd_data == 20'h0));

    // R5: never two grants at once.
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    // R5: an owner change passes through an all-high clock.
    a_r5_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_n) != 4'hF && gnt_n != $past(gnt_n)) |-> gnt_n == 4'hF);

    // R6: a non-preemptable owner with an eligible request keeps the bus.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((~gnt_n & ~req_n & ~masked & ~rd_data[9:6]) != 4'h0)
        |=> gnt_n == $past(gnt_n));

    // R13: idle bus with no requests comes to rest on the host.
    a_r13_park: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n == 4'hF && req_n == 4'hF) |=> gnt_n == 4'b0111);

    // R11: a clear command empties the status bits.
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[14]) |=> rd_data[17:15] == 3'b000);

    // R12: reserved and clear positions read zero.
    a_r12_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[19:18] == 2'b00 && !rd_data[14]);

    // R10: a status bit only rises for a master that held the grant.
    for (genvar m = 0; m < 3; m++) begin : g_stat
        a_r10_only_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_data[15+m]) |-> $past(!gnt_n[m]));
    end
endmodule

bind pci_hybrid_arbiter arb_checker u_arb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .gnt_n   (gnt_n),
    .rd_data (rd_data),
    .masked  (masked_q)
);

// File: tb/test_pci_hybrid_arbiter.sv
// Bench: behavioural reference model compared with the design every clock,
// plus directed sequences for timing, status and reserved bits.
module test_pci_hybrid_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   req_n = 4'hF;
    logic         frame_n = 1'b1;
    logic         retry = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    wire  [3:0]   gnt_n;
    wire  [W-1:0] rd_data;

    int    vectors = 0;
    int    miscompares = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_hybrid_arbiter i_pci_hybrid_arbiter (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
        .retry(retry), .wr_en(wr_en), .wr_data(wr_data),
        .gnt_n(gnt_n), .rd_data(rd_data)
    );

    // Reference model state.
    int       m_hold;
    bit [2:0] m_rot, m_keep, m_fix, m_brk, eff;
    bit [3:0] m_pe, m_re, m_msk, nmsk, reqv, elig, oth;
    int       m_cnt[3];
    bit       m_arm[3];
    int       win, nh;
    bit       issue, lv;

    // Preference list from the node bits; first eligible entry wins.
    function automatic int pick(bit [3:0] e, bit [2:0] f);
        int ord[4];
        int a0 = f[0] ? 1 : 0;
        int a1 = f[0] ? 0 : 1;
        int b0 = f[1] ? 3 : 2;
        int b1 = f[1] ? 2 : 3;
        if (f[2]) ord = '{b0, b1, a0, a1};
        else      ord = '{a0, a1, b0, b1};
        foreach (ord[k]) if (e[ord[k]]) return ord[k];
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 3; m_rot = 0; m_keep = 0; m_fix = 0; m_brk = 0;
            m_pe = 0; m_re = 0; m_msk = 0;
            for (int m = 0; m < 3; m++) begin m_cnt[m] = 0; m_arm[m] = 0; end
        end else begin
            reqv = ~req_n;
            elig = reqv & ~m_msk;
            for (int i = 0; i < 3; i++) eff[i] = m_keep[i] ? m_fix[i] : m_rot[i];
            win = pick(elig, eff);
            issue = 0;
            if (m_hold < 0) begin
                nh = (win >= 0) ? win : 3;
                issue = (win >= 0);
            end else begin
                lv = (!elig[m_hold] || m_pe[m_hold]) &&
                     ((win >= 0) ? (win != m_hold) : (m_hold != 3));
                nh = lv ? -1 : m_hold;
            end
            for (int m = 0; m < 4; m++) begin
                nmsk[m] = m_msk[m];
                oth = reqv; oth[m] = 0;
                if (m_msk[m] && ((issue && win != m) || oth == 0)) nmsk[m] = 0;
                if (retry && m_hold == m && m_re[m]) nmsk[m] = 1;
            end
            for (int m = 0; m < 3; m++) begin
                if (m_hold == m && m_arm[m]) begin
                    if (!frame_n) m_arm[m] = 0;
                    else if (m_cnt[m] == 15) begin m_brk[m] = 1; m_arm[m] = 0; end
                    else m_cnt[m]++;
                end else if (nh == m && m_hold != m) begin
                    m_cnt[m] = 0; m_arm[m] = 1;
                end
            end
            if (wr_en && wr_data[14]) m_brk = 0;
            if (wr_en) begin
                m_keep = wr_data[2:0]; m_fix = wr_data[5:3];
                m_pe = wr_data[9:6];   m_re = wr_data[13:10];
            end
            if (issue) begin
                if (win < 2) begin m_rot[0] = (win == 0); m_rot[2] = 1; end
                else         begin m_rot[1] = (win == 2); m_rot[2] = 0; end
            end
            m_hold = nh;
            m_msk  = nmsk;
        end
    end

    // Compare design outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [3:0]   eg;
            logic [W-1:0] er;
            eg = (m_hold < 0) ? 4'hF : ~(4'b0001 << m_hold);
            er = {2'b00, m_brk, 1'b0, m_re, m_pe, m_fix, m_keep};
            vectors++;
            if (gnt_n !== eg || rd_data !== er) begin
                miscompares++;
                $display("FAIL %s: gnt_n=%b rd_data=%h expected gnt_n=%b rd_data=%h",
                         tag, gnt_n, rd_data, eg, er);
            end
        end
    end

    task automatic check_val(string t, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic run_phase(string t, logic [W-1:0] cfg, int n);
        tag = t;
        @(negedge clk); wr_en = 1; wr_data = cfg;
        @(negedge clk); wr_en = 0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 4; b++) if ($urandom % 4 == 0) req_n[b] = ~req_n[b];
            frame_n = ($urandom % 8) != 0;
            retry   = ($urandom % 6) == 0;
            if ($urandom % 97 == 0) begin wr_en = 1; wr_data = cfg | 20'h04000; end
            else wr_en = 0;
            @(negedge clk);
        end
        wr_en = 0; retry = 0; frame_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): actual running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        chk_on = 1;
        repeat (2) @(negedge clk);
        check_val("R1 grant", {16'h0, gnt_n}, 20'h00007);
        check_val("R1 register", rd_data, 20'h0);
        rst_n = 1;

        run_phase("R2 R3 R5 R6 R13", 20'h00000, 400);
        run_phase("R4 fixed", 20'h0002F, 400);
        run_phase("R4 R2 mixed", 20'h00012, 400);
        run_phase("R7", 20'h003C0, 400);
        run_phase("R8 R9", 20'h03C00, 400);
        run_phase("R7 R8 R9 R10 R11", 20'h03FE1, 400);

        // R10: exact edge count of the broken-master detection on master 1.
        tag = "R10";
        req_n = 4'hF; wr_en = 1; wr_data = 20'h04000;
        @(negedge clk); wr_en = 0;
        repeat (3) @(negedge clk);
        req_n = 4'b1101;
        for (int k = 0; k < 20 && gnt_n !== 4'b1101; k++) @(negedge clk);
        repeat (15) @(negedge clk);
        check_val("R10 after 15 edges", {19'h0, rd_data[16]}, 20'h0);
        @(negedge clk);
        check_val("R10 after 16 edges", {19'h0, rd_data[16]}, 20'h1);

        // R11: direct writes to status are ignored, the clear bit empties it.
        tag = "R11";
        wr_en = 1; wr_data = 20'h38000;
        @(negedge clk); wr_en = 0;
        check_val("R11 status write ignored", rd_data, 20'h10000);
        wr_en = 1; wr_data = 20'h04000;
        @(negedge clk); wr_en = 0;
        check_val("R11 clear", rd_data, 20'h00000);

        // R12: all-ones write reads back only the control fields.
        tag = "R12";
        wr_en = 1; wr_data = 20'hFFFFF;
        @(negedge clk); wr_en = 0;
        check_val("R12 reserved zero", rd_data, 20'h03FFF);

        // R13: with no requests the grant comes to rest on the host.
        tag = "R13";
        req_n = 4'hF;
        repeat (3) @(negedge clk);
        check_val("R13 park", {16'h0, gnt_n}, 20'h00007);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule